// File: doc/BRIEF.md
# Multi-Event Buffer Readout Controller

This block keeps a ring of event buffers filled by an acquisition write side and hands them to a host over a small register port. The write side drops in one finished event per `evt_valid` pulse. Each event carries a time tag, an event counter, a per-channel word count and the sample words for every channel. The ring holds `NBUF` events. An event that arrives while every slot is taken is thrown away and counted as lost.

The host reads events in one of two ways. In sequential polling the host reads the size register to learn how many 32-bit words the oldest event holds. It then reads exactly that many words from the sequential data address. After the last word, that buffer is released on its own. In random readout the host first writes a block request naming a channel and a word count. It then reads a header, the time tag, the counter and that channel's words from the random data address. The request is used up by that one readout, and the buffer stays held. The host frees buffers itself by writing a count to the release register, which frees the oldest buffers first.

A read engine built as a state machine handles the host side. Its states are `RD_IDLE` (no readout in progress), `RD_SEQ` (part way through a sequential event), `RD_ARMED` (a request is pending and no word of it has been read yet) and `RD_RND` (part way through a requested readout). The transitions are as follows:
- IDLE→SEQ on a sequential read of an event longer than one word.
- SEQ→IDLE on the last sequential word.
- any→ARMED on a request write.
- ARMED→RND on the first random read.
- RND→IDLE on the last requested word.
- ARMED→IDLE on a random read when no event is present.
- any→IDLE on a release write.

Top module: `mebuf_readout`

## Requirements
- R1: After reset the size register (address 0) reads 0, the lost counter (address 5) reads 0, and no buffer is occupied.
- R2: The size register returns 3 + NCH × L for the oldest occupied event, where L is that event's words per channel, and returns 0 with no bus error when no buffer is occupied.
- R3: Successive reads of address 3 return the oldest event as follows, in this order: a header word `{4'hA, 12'h000, size[15:0]}`, the time tag, the event counter, channel 0's L words and then each further channel's L words. After the last word the buffer is released and the size register shows the next event.
- R4: A data read (address 3 or 4) while no buffer is occupied returns data 0 with a bus error.
- R5: A read of address 4 with no pending block request gets a bus error. A request is written to address 2 with the channel in bits [7:0] and the word count N in bits [23:16]. Each request serves one readout of 3 + N words, and a further read of address 4 after that gets a bus error.
- R6: A random readout of the oldest event returns, in this order, a header `{4'hA, 12'h000, (3+N)[15:0]}` carrying the requested size, the time tag, the counter and N words of the chosen channel. Positions at or beyond the stored length read 0. The buffer is not released.
- R7: A write of n to address 1 releases the n oldest buffers. If n exceeds the occupancy, all buffers are cleared with no bus error.
- R8: At most NBUF events are held. An event arriving while all are full is dropped and the lost counter increments.
- R9: Every read gets a response one cycle later with `host_rvalid` high for exactly that cycle. `host_berr` is high only together with such a response.
- R10: A read of address 3 while a block request is pending or in progress gets a bus error and leaves the request and its position unchanged.
- R11: A request write or a release write abandons any partial readout. The next sequential or random read starts again from the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle pulse depositing an event |
| evt_ttag | input | 32 | Time tag of the event |
| evt_count | input | 32 | Event counter value |
| evt_len | input | 3 | Words per channel, 1..MAXW |
| evt_samples | input | 256 | Channel c word w at bits [(c·MAXW+w)·32 +: 32] |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, one cycle after the strobe |
| host_rvalid | output | 1 | Read response pulse |
| host_berr | output | 1 | Bus error pulse with the response |

## Verification
The assertions assume that the host raises at most one of `host_rd` and `host_wr` in a cycle. They also assume that `evt_len` lies between 1 and MAXW, so the sequential word count always ends on a channel boundary. The bench issues every access through a task that drives one strobe for one cycle and drops it before the next. It also deposits events only with lengths inside that range. The wrap of the release arithmetic requires NBUF to be a power of two, and the bench keeps the default.

// File: rtl/mebuf_pkg.sv
package mebuf_pkg;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_SEQ   = 2'd1,
        RD_ARMED = 2'd2,
        RD_RND   = 2'd3
    } rd_state_e;

    localparam logic [2:0] A_SIZE  = 3'd0;
    localparam logic [2:0] A_FREE  = 3'd1;
    localparam logic [2:0] A_REQ   = 3'd2;
    localparam logic [2:0] A_SEQ   = 3'd3;
    localparam logic [2:0] A_RND   = 3'd4;
    localparam logic [2:0] A_LOST  = 3'd5;

    localparam logic [3:0] HDR_MARK = 4'hA;

endpackage

// File: rtl/mebuf_store.sv
module mebuf_store #(
    parameter int NBUF = 8,
    parameter int NCH  = 2,
    parameter int MAXW = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [31:0]               push_ttag,
    input  logic [31:0]               push_cnt,
    input  logic [$clog2(MAXW+1)-1:0] push_len,
    input  logic [NCH*MAXW*32-1:0]    push_data,
    input  logic                      rel_valid,
    input  logic [31:0]               rel_cnt,
    input  logic [7:0]                smp_ch,
    input  logic [7:0]                smp_w,
    output logic                      head_valid,
    output logic [31:0]               head_ttag,
    output logic [31:0]               head_cnt,
    output logic [$clog2(MAXW+1)-1:0] head_len,
    output logic [31:0]               smp_data,
    output logic [31:0]               lost_cnt
);
    localparam int BUFW = $clog2(NBUF);
    localparam int OCW  = $clog2(NBUF + 1);
    localparam int LENW = $clog2(MAXW + 1);
    localparam int NSW  = NCH * MAXW;
    localparam int IW   = (NSW > 1) ? $clog2(NSW) : 1;
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int WW   = (MAXW > 1) ? $clog2(MAXW) : 1;

    logic [31:0]     ttag_mem [NBUF];
    logic [31:0]     cnt_mem  [NBUF];
    logic [LENW-1:0] len_mem  [NBUF];
    logic [31:0]     smp_mem  [NBUF][NSW];

    logic [BUFW-1:0] wr_ptr, rd_ptr;
    logic [OCW-1:0]  occ, rel_n;
    logic            full, push_ok;
    logic [IW-1:0]   sidx;

    assign full    = (occ == OCW'(NBUF));
    assign push_ok = push && !full;

    always_comb begin
        if (!rel_valid)
            rel_n = '0;
        else if (rel_cnt > 32'(occ))
            rel_n = occ;
        else
            rel_n = rel_cnt[OCW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            occ      <= '0;
            lost_cnt <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= wr_ptr + BUFW'(1);
            rd_ptr <= rd_ptr + BUFW'(rel_n);
            occ    <= occ - rel_n + OCW'(push_ok);
            if (push && full)
                lost_cnt <= lost_cnt + 32'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            ttag_mem[wr_ptr] <= push_ttag;
            cnt_mem[wr_ptr]  <= push_cnt;
            len_mem[wr_ptr]  <= push_len;
            for (int k = 0; k < NSW; k++)
                smp_mem[wr_ptr][k] <= push_data[k*32 +: 32];
        end
    end

    assign head_valid = (occ != '0);
    assign head_ttag  = ttag_mem[rd_ptr];
    assign head_cnt   = cnt_mem[rd_ptr];
    assign head_len   = len_mem[rd_ptr];

    always_comb begin
        sidx = IW'(smp_ch[CHW-1:0]) * IW'(MAXW) + IW'(smp_w[WW-1:0]);
        if (head_valid && (smp_ch < 8'(NCH)) && (smp_w < 8'(head_len)))
            smp_data = smp_mem[rd_ptr][sidx];
        else
            smp_data = '0;
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCW'(NBUF));

    assert_drop_counted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && occ == OCW'(NBUF) && !rel_valid) |=> (lost_cnt == $past(lost_cnt) + 32'd1));

    assert_free_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && rel_cnt >= 32'(occ) && !push) |=> (occ == '0));

endmodule

// File: rtl/mebuf_rdctl.sv
module mebuf_rdctl
    import mebuf_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int MAXW = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                host_addr,
    input  logic                      host_wr,
    input  logic                      host_rd,
    input  logic [31:0]               host_wdata,
    output logic [31:0]               host_rdata,
    output logic                      host_rvalid,
    output logic                      host_berr,
    input  logic                      head_valid,
    input  logic [31:0]               head_ttag,
    input  logic [31:0]               head_cnt,
    input  logic [$clog2(MAXW+1)-1:0] head_len,
    input  logic [31:0]               smp_data,
    input  logic [31:0]               lost_cnt,
    output logic [7:0]                smp_ch,
    output logic [7:0]                smp_w,
    output logic                      rel_valid,
    output logic [31:0]               rel_cnt
);
    rd_state_e   state, state_n;
    logic [8:0]  pos, pos_n;
    logic [7:0]  ch_q, ch_n, w_q, w_n;
    logic [7:0]  rq_ch, rq_ch_n, rq_len, rq_len_n;
    logic [31:0] resp_data;
    logic        resp_err;
    logic [15:0] seq_size, rnd_size;
    logic [31:0] seq_word, rnd_word;
    logic        seq_last, rnd_last;

    assign seq_size = 16'd3 + 16'(NCH) * 16'(head_len);
    assign rnd_size = 16'd3 + 16'(rq_len);
    assign seq_last = (16'(pos) == seq_size - 16'd1);
    assign rnd_last = (pos == 9'd2 + 9'(rq_len));
    assign smp_ch   = (state == RD_ARMED || state == RD_RND) ? rq_ch : ch_q;
    assign smp_w    = w_q;

    always_comb begin
        unique case (pos)
            9'd0:    seq_word = {HDR_MARK, 12'h000, seq_size};
            9'd1:    seq_word = head_ttag;
            9'd2:    seq_word = head_cnt;
            default: seq_word = smp_data;
        endcase
        unique case (pos)
            9'd0:    rnd_word = {HDR_MARK, 12'h000, rnd_size};
            9'd1:    rnd_word = head_ttag;
            9'd2:    rnd_word = head_cnt;
            default: rnd_word = smp_data;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RD_IDLE;
            pos         <= '0;
            ch_q        <= '0;
            w_q         <= '0;
            rq_ch       <= '0;
            rq_len      <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
            host_berr   <= 1'b0;
        end else begin
            state       <= state_n;
            pos         <= pos_n;
            ch_q        <= ch_n;
            w_q         <= w_n;
            rq_ch       <= rq_ch_n;
            rq_len      <= rq_len_n;
            host_rdata  <= resp_data;
            host_rvalid <= host_rd;
            host_berr   <= host_rd && resp_err;
        end
    end

    // next state and outputs
    always_comb begin
        state_n   = state;
        pos_n     = pos;
        ch_n      = ch_q;
        w_n       = w_q;
        rq_ch_n   = rq_ch;
        rq_len_n  = rq_len;
        resp_data = '0;
        resp_err  = 1'b0;
        rel_valid = 1'b0;
        rel_cnt   = '0;

        if (host_wr) begin
            if (host_addr == A_FREE) begin
                rel_valid = 1'b1;
                rel_cnt   = host_wdata;
                state_n   = RD_IDLE;
                pos_n     = '0;
                ch_n      = '0;
                w_n       = '0;
            end else if (host_addr == A_REQ) begin
                rq_ch_n  = host_wdata[7:0];
                rq_len_n = host_wdata[23:16];
                state_n  = RD_ARMED;
                pos_n    = '0;
                ch_n     = '0;
                w_n      = '0;
            end
        end else if (host_rd) begin
            if (host_addr == A_SIZE) begin
                resp_data = head_valid ? 32'(seq_size) : 32'd0;
            end else if (host_addr == A_LOST) begin
                resp_data = lost_cnt;
            end else if (host_addr == A_SEQ) begin
                unique case (state)
                    RD_ARMED, RD_RND: resp_err = 1'b1;
                    RD_IDLE, RD_SEQ: begin
                        if (!head_valid) begin
                            resp_err = 1'b1;
                        end else begin
                            resp_data = seq_word;
                            if (seq_last) begin
                                rel_valid = 1'b1;
                                rel_cnt   = 32'd1;
                                state_n   = RD_IDLE;
                                pos_n     = '0;
                                ch_n      = '0;
                                w_n       = '0;
                            end else begin
                                state_n = RD_SEQ;
                                pos_n   = pos + 9'd1;
                                if (pos >= 9'd3) begin
                                    if (w_q + 8'd1 == 8'(head_len)) begin
                                        w_n  = '0;
                                        ch_n = ch_q + 8'd1;
                                    end else begin
                                        w_n = w_q + 8'd1;
                                    end
                                end
                            end
                        end
                    end
                endcase
            end else if (host_addr == A_RND) begin
                unique case (state)
                    RD_IDLE, RD_SEQ: resp_err = 1'b1;
                    RD_ARMED, RD_RND: begin
                        if (!head_valid) begin
                            resp_err = 1'b1;
                            state_n  = RD_IDLE;
                            pos_n    = '0;
                            w_n      = '0;
                        end else begin
                            resp_data = rnd_word;
                            if (rnd_last) begin
                                state_n = RD_IDLE;
                                pos_n   = '0;
                                w_n     = '0;
                            end else begin
                                state_n = RD_RND;
                                pos_n   = pos + 9'd1;
                                if (pos >= 9'd3)
                                    w_n = w_q + 8'd1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    assert_resp_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);

    assert_no_spurious_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);

    assert_err_with_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_berr |-> host_rvalid);

    assert_unarmed_berr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == A_RND && (state == RD_IDLE || state == RD_SEQ))
        |=> host_berr);

    assert_empty_berr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == A_SEQ && !head_valid) |=> host_berr);

    assert_seq_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == A_SEQ && (state == RD_ARMED || state == RD_RND))
        |=> (host_berr && state == $past(state) && pos == $past(pos)));

endmodule

// File: rtl/mebuf_readout.sv
module mebuf_readout #(
    parameter int NBUF = 8,
    parameter int NCH  = 2,
    parameter int MAXW = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      evt_valid,
    input  logic [31:0]               evt_ttag,
    input  logic [31:0]               evt_count,
    input  logic [$clog2(MAXW+1)-1:0] evt_len,
    input  logic [NCH*MAXW*32-1:0]    evt_samples,
    input  logic [2:0]                host_addr,
    input  logic                      host_wr,
    input  logic                      host_rd,
    input  logic [31:0]               host_wdata,
    output logic [31:0]               host_rdata,
    output logic                      host_rvalid,
    output logic                      host_berr
);
    localparam int LENW = $clog2(MAXW + 1);

    logic            head_valid, rel_valid;
    logic [31:0]     head_ttag, head_cnt, smp_data, lost_cnt, rel_cnt;
    logic [LENW-1:0] head_len;
    logic [7:0]      smp_ch, smp_w;

    mebuf_store #(.NBUF(NBUF), .NCH(NCH), .MAXW(MAXW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (evt_valid),
        .push_ttag  (evt_ttag),
        .push_cnt   (evt_count),
        .push_len   (evt_len),
        .push_data  (evt_samples),
        .rel_valid  (rel_valid),
        .rel_cnt    (rel_cnt),
        .smp_ch     (smp_ch),
        .smp_w      (smp_w),
        .head_valid (head_valid),
        .head_ttag  (head_ttag),
        .head_cnt   (head_cnt),
        .head_len   (head_len),
        .smp_data   (smp_data),
        .lost_cnt   (lost_cnt)
    );

    mebuf_rdctl #(.NCH(NCH), .MAXW(MAXW)) u_rdctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .host_berr   (host_berr),
        .head_valid  (head_valid),
        .head_ttag   (head_ttag),
        .head_cnt    (head_cnt),
        .head_len    (head_len),
        .smp_data    (smp_data),
        .lost_cnt    (lost_cnt),
        .smp_ch      (smp_ch),
        .smp_w       (smp_w),
        .rel_valid   (rel_valid),
        .rel_cnt     (rel_cnt)
    );

endmodule

// File: tb/mebuf_readout_test.sv
module mebuf_readout_test;
    localparam int NBUF = 8;
    localparam int NCH  = 2;
    localparam int MAXW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              evt_valid = 1'b0;
    logic [31:0]       evt_ttag = '0, evt_count = '0;
    logic [2:0]        evt_len = '0;
    logic [NCH*MAXW*32-1:0] evt_samples = '0;
    logic [2:0]        host_addr = '0;
    logic              host_wr = 1'b0, host_rd = 1'b0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              host_rvalid, host_berr;

    int checks = 0;
    int errors = 0;
    logic [31:0] r_data;
    logic        r_err, r_vld;

    mebuf_readout #(.NBUF(NBUF), .NCH(NCH), .MAXW(MAXW)) uut (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] pat(int e, int c, int w);
        return 32'h1000_0000 | 32'(e << 8) | 32'(c << 4) | 32'(w);
    endfunction

    function automatic logic [31:0] hdr(int size);
        return 32'hA000_0000 | 32'(size);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push_evt(input int e, input int len);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_ttag  = 32'h5000 + 32'(e);
        evt_count = 32'(e);
        evt_len   = 3'(len);
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < MAXW; w++)
                evt_samples[(c*MAXW+w)*32 +: 32] = pat(e, c, w);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a);
        @(negedge clk);
        host_addr = a;
        host_rd   = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        r_data = host_rdata;
        r_err  = host_berr;
        r_vld  = host_rvalid;
    endtask

    task automatic host_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic expect_word(input logic [2:0] a, input logic [31:0] exp, input string req);
        host_read(a);
        check(r_vld && !r_err && r_data == exp, req, r_data, exp);
    endtask

    task automatic expect_berr(input logic [2:0] a, input string req);
        host_read(a);
        check(r_vld && r_err && r_data == 32'd0, req, {31'd0, r_err}, 32'd1);
    endtask

    task automatic t_reset;
        expect_word(3'd0, 32'd0, "R1 size after reset");
        expect_word(3'd5, 32'd0, "R1 lost after reset");
        expect_berr(3'd3, "R4 seq read empty");
        expect_berr(3'd4, "R4 rnd read empty");
    endtask

    task automatic t_sequential;
        push_evt(1, 2);
        expect_word(3'd0, 32'd7, "R2 size of event");
        expect_word(3'd3, hdr(7), "R3 header");
        expect_word(3'd3, 32'h5001, "R3 time tag");
        expect_word(3'd3, 32'd1, "R3 counter");
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 2; w++)
                expect_word(3'd3, pat(1, c, w), "R3 sample");
        expect_word(3'd0, 32'd0, "R2 R3 size after auto release");
        expect_berr(3'd3, "R4 seq read after drain");
    endtask

    task automatic t_random;
        push_evt(2, 2);
        push_evt(3, 3);
        expect_berr(3'd4, "R5 rnd without request");
        host_write(3'd2, (32'd3 << 16) | 32'd1);
        expect_word(3'd4, hdr(6), "R6 header requested size");
        expect_word(3'd4, 32'h5002, "R6 time tag");
        expect_word(3'd4, 32'd2, "R6 counter");
        expect_word(3'd4, pat(2, 1, 0), "R6 ch1 w0");
        expect_word(3'd4, pat(2, 1, 1), "R6 ch1 w1");
        expect_word(3'd4, 32'd0, "R6 beyond stored length");
        expect_berr(3'd4, "R5 request consumed");
        expect_word(3'd0, 32'd7, "R6 buffer not released");
        host_write(3'd2, (32'd1 << 16) | 32'd0);
        expect_word(3'd4, hdr(4), "R6 second request header");
        expect_word(3'd4, 32'h5002, "R6 second time tag");
        expect_word(3'd4, 32'd2, "R6 second counter");
        expect_word(3'd4, pat(2, 0, 0), "R6 ch0 w0");
    endtask

    task automatic t_free;
        host_write(3'd1, 32'd1);
        check(!host_berr && !host_rvalid, "R7 free write no error", {31'd0, host_berr}, 32'd0);
        expect_word(3'd0, 32'd9, "R7 free one oldest");
        push_evt(4, 1);
        push_evt(5, 1);
        host_write(3'd1, 32'd10);
        check(!host_berr, "R7 excess free no error", {31'd0, host_berr}, 32'd0);
        expect_word(3'd0, 32'd0, "R7 excess free clears all");
        expect_word(3'd5, 32'd0, "R8 no loss yet");
    endtask

    task automatic t_full;
        for (int e = 10; e < 10 + NBUF + 1; e++)
            push_evt(e, 1);
        expect_word(3'd5, 32'd1, "R8 lost counter");
        expect_word(3'd0, 32'd5, "R8 oldest kept");
        expect_word(3'd3, hdr(5), "R8 head header");
        expect_word(3'd3, 32'h500A, "R8 head is first event");
        expect_word(3'd3, 32'd10, "R8 head counter");
        expect_word(3'd3, pat(10, 0, 0), "R8 head ch0");
        expect_word(3'd3, pat(10, 1, 0), "R8 head ch1");
        expect_word(3'd3, hdr(5), "R3 next event header");
        host_write(3'd1, 32'd8);
        expect_word(3'd0, 32'd0, "R7 free remaining");
    endtask

    task automatic t_latency;
        @(negedge clk);
        host_addr = 3'd0;
        host_rd   = 1'b1;
        #1;
        check(!host_rvalid, "R9 no response before edge", {31'd0, host_rvalid}, 32'd0);
        @(negedge clk);
        host_rd = 1'b0;
        check(host_rvalid && !host_berr, "R9 response next cycle", {31'd0, host_rvalid}, 32'd1);
        @(negedge clk);
        check(!host_rvalid, "R9 response is one pulse", {31'd0, host_rvalid}, 32'd0);
    endtask

    task automatic t_conflict;
        push_evt(20, 1);
        host_write(3'd2, (32'd1 << 16) | 32'd0);
        expect_berr(3'd3, "R10 seq while armed");
        expect_word(3'd4, hdr(4), "R10 request intact");
        expect_word(3'd4, 32'h5014, "R6 tag");
        expect_berr(3'd3, "R10 seq while in progress");
        expect_word(3'd4, 32'd20, "R10 position kept");
        expect_word(3'd4, pat(20, 0, 0), "R6 last word");
    endtask

    task automatic t_abandon;
        expect_word(3'd3, hdr(5), "R11 seq start");
        expect_word(3'd3, 32'h5014, "R11 seq tag");
        host_write(3'd1, 32'd0);
        expect_word(3'd3, hdr(5), "R11 free restarts seq");
        expect_word(3'd3, 32'h5014, "R11 seq tag again");
        host_write(3'd2, 32'd0);
        expect_word(3'd4, hdr(3), "R11 request restarts at header");
        expect_word(3'd4, 32'h5014, "R11 rnd tag");
        expect_word(3'd4, 32'd20, "R11 rnd counter");
        expect_berr(3'd4, "R5 zero-length request consumed");
        expect_word(3'd0, 32'd5, "R11 event still held");
        host_write(3'd1, 32'd8);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sequential();
        t_random();
        t_free();
        t_full();
        t_latency();
        t_conflict();
        t_abandon();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule